// File: doc/BRIEF.md
# Field-Locked Audio Clock Generator

This block derives an audio master clock from a fast system clock. The master clock is produced by a numerically controlled oscillator, so it shares the same reference as the video timing. The oscillator is steered so that every video field holds a programmed number of master-clock periods. At each field-sync pulse, the block compares the number of master-clock enables counted during the field that just ended with the programmed target. It then trims the oscillator increment by a small, shifted fraction of the difference. The loop is deliberately slow, so capture and playback paths never drift apart.

From the master clock the block also divides down a serial bit clock and a left/right channel-select clock. The bit-clock divider and the channel-select divider are set by separate inputs. The channel-select clock changes only when the bit clock falls, so a serial receiver sees a stable channel select around its sampling edge. A lock flag reports that the field count has stayed on target. If field pulses stop for too long, the block drops lock and freezes the increment.

Top module: `audio_field_clkgen`

## Requirements
- R1: While rst_n is low and on the first cycle after it, mclk_en, bck, lrck and locked are 0, and the increment equals INIT_INC.
- R2: mclk_en is the carry out of an ACC_W-bit phase accumulator that adds the increment on every cycle, registered. With a constant increment, N cycles carry floor(N*inc/2^ACC_W) enables, give or take one.
- R3: The measured count of a field is the number of cycles with mclk_en high, from the cycle after one field_sync pulse through the cycle of the next pulse. The error is mclk_per_field minus that count. On that pulse, the increment, which is held with TRIM_SH extra fraction bits, gains (error << ERR_SH) in fraction units. The result is clamped between 1 and 2^ACC_W-1 whole units.
- R4: With field pulses at a steady period and a reachable target, the measured count converges to mclk_per_field and locked rises.
- R5: A field is good when its error lies in -1..+1. locked is 1 on the cycle after a pulse that ends the LOCK_N-th consecutive good field. It is 0 on the cycle after a pulse that ends a field that is not good.
- R6: The first field_sync pulse after reset or after a stall only starts a measurement. It neither trims the increment nor counts toward lock, so relock after a stall needs LOCK_N+1 pulses.
- R7: When STALL_LIMIT cycles pass with no field_sync pulse, locked is 0 from the next cycle and the good-field run is cleared. The increment is held, so the mclk_en rate during and after the stall is unchanged.
- R8: bck toggles on the cycle after every (bck_div+1)-th mclk_en pulse, and at no other time.
- R9: lrck toggles only on the same clock edge at which bck falls, once for every lr_div+1 falling edges of bck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_sync | input | 1 | One-cycle pulse per video field |
| mclk_per_field | input | CNT_W | Target master clocks per field |
| bck_div | input | SDIV_W | Bit-clock divider: half period is bck_div+1 master clocks |
| lr_div | input | LRDIV_W | Channel-select divider: half period is lr_div+1 bit-clock periods |
| mclk_en | output | 1 | Master clock enable, one cycle wide |
| bck | output | 1 | Serial bit clock |
| lrck | output | 1 | Left/right channel-select clock |
| locked | output | 1 | Field count held within one of the target |

## Verification
Each result has a fixed latency. mclk_en appears one cycle after the accumulator wraps. bck moves one cycle after the enable that completes its half period. lrck moves together with that bck fall. locked and the trimmed increment both take effect on the cycle after the field_sync pulse that closes a field, and a stall clears lock one cycle after the limit is reached. The bench samples every output on the falling clock edge. At that same edge it drives field_sync and updates its own lock, stall and field-count model for the rising edge that follows, so each expectation is compared exactly one register stage after the stimulus that causes it. Rate and trim results are checked against counts computed arithmetically from the increment, allowing a tolerance of one enable.

// File: rtl/audio_field_clkgen.sv
`timescale 1ns/1ps
module audio_field_clkgen #(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 18,
  parameter int SDIV_W      = 6,
  parameter int LRDIV_W     = 8,
  parameter int TRIM_SH     = 8,
  parameter int ERR_SH      = 16,
  parameter int LOCK_N      = 4,
  parameter int STALL_LIMIT = 1 << 20,
  parameter logic [ACC_W-1:0] INIT_INC = ACC_W'(1) << (ACC_W - 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_sync,
  input  logic [CNT_W-1:0]   mclk_per_field,
  input  logic [SDIV_W-1:0]  bck_div,
  input  logic [LRDIV_W-1:0] lr_div,
  output logic               mclk_en,
  output logic               bck,
  output logic               lrck,
  output logic               locked
);
  localparam int IW = ACC_W + TRIM_SH;
  localparam int FW = CNT_W + 1;
  localparam int MW = CNT_W + 2;
  localparam int EW = CNT_W + 3;
  localparam int SW = IW + EW + ERR_SH + 2;
  localparam int GW = $clog2(STALL_LIMIT + 1);
  localparam int KW = $clog2(LOCK_N + 1);
  localparam logic [SW-1:0] ONE_W = {{(SW-1){1'b0}}, 1'b1};
  localparam logic signed [SW-1:0] INC_LO = ONE_W << TRIM_SH;
  localparam logic signed [SW-1:0] INC_HI = ((ONE_W << ACC_W) - ONE_W) << TRIM_SH;

  logic [ACC_W-1:0] acc, acc_nx, inc;
  logic             carry;
  logic [IW-1:0]    inc_q, inc_nx;

  assign inc = inc_q[IW-1:TRIM_SH];
  assign {carry, acc_nx} = {1'b0, acc} + {1'b0, inc};

  logic [FW-1:0]        fcnt;
  logic [MW-1:0]        meas;
  logic signed [EW-1:0] err;
  logic signed [SW-1:0] err_x, sum;
  logic                 good;

  assign meas  = {1'b0, fcnt} + MW'(mclk_en);
  assign err   = signed'({3'b000, mclk_per_field}) - signed'({1'b0, meas});
  assign good  = (err <= 1) && (err >= -1);
  assign err_x = {{(SW-EW){err[EW-1]}}, err} <<< ERR_SH;
  assign sum   = signed'({{(SW-IW){1'b0}}, inc_q}) + err_x;

  always_comb begin
    if (sum < INC_LO)      inc_nx = INC_LO[IW-1:0];
    else if (sum > INC_HI) inc_nx = INC_HI[IW-1:0];
    else                   inc_nx = sum[IW-1:0];
  end

  logic [GW-1:0] gap;
  logic [KW-1:0] streak;
  logic          primed, stale;

  assign stale = !field_sync && (gap == GW'(STALL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      mclk_en <= 1'b0;
      inc_q   <= {INIT_INC, {TRIM_SH{1'b0}}};
      fcnt    <= '0;
      gap     <= '0;
      streak  <= '0;
      primed  <= 1'b0;
      locked  <= 1'b0;
    end else begin
      acc     <= acc_nx;
      mclk_en <= carry;
      if (field_sync) begin
        gap    <= '0;
        fcnt   <= '0;
        primed <= 1'b1;
        if (primed) begin
          inc_q <= inc_nx;
          if (good) begin
            streak <= (streak == KW'(LOCK_N)) ? streak : streak + KW'(1);
            locked <= (streak >= KW'(LOCK_N - 1));
          end else begin
            streak <= '0;
            locked <= 1'b0;
          end
        end
      end else begin
        if (gap != GW'(STALL_LIMIT)) gap <= gap + GW'(1);
        if (!(&fcnt)) fcnt <= fcnt + FW'(mclk_en);
        if (stale) begin
          primed <= 1'b0;
          streak <= '0;
          locked <= 1'b0;
        end
      end
    end
  end

  logic [SDIV_W-1:0]  bdiv;
  logic [LRDIV_W-1:0] ldiv;
  logic               bwrap, bfall;

  assign bwrap = mclk_en && (bdiv >= bck_div);
  assign bfall = bwrap && bck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bdiv <= '0;
      ldiv <= '0;
      bck  <= 1'b0;
      lrck <= 1'b0;
    end else begin
      if (mclk_en) bdiv <= bwrap ? '0 : bdiv + SDIV_W'(1);
      if (bwrap)   bck  <= ~bck;
      if (bfall) begin
        if (ldiv >= lr_div) begin
          ldiv <= '0;
          lrck <= ~lrck;
        end else begin
          ldiv <= ldiv + LRDIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/audio_field_clkgen_chk.sv
`timescale 1ns/1ps
module audio_field_clkgen_chk #(
  parameter int STALL_LIMIT = 1 << 20
) (
  input logic clk,
  input logic rst_n,
  input logic field_sync,
  input logic mclk_en,
  input logic bck,
  input logic lrck,
  input logic locked
);
  localparam int GW = $clog2(STALL_LIMIT + 1);
  logic [GW-1:0] gap_c;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_c <= '0;
    else if (field_sync) gap_c <= '0;
    else if (gap_c != GW'(STALL_LIMIT)) gap_c <= gap_c + GW'(1);
  end

  p_bck_after_mclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bck) |-> $past(mclk_en));

  p_lr_on_bck_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bck));

  p_lock_rise_on_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(field_sync));

  p_stall_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_c == GW'(STALL_LIMIT - 1) && !field_sync) |=> !locked);
endmodule

bind audio_field_clkgen audio_field_clkgen_chk #(.STALL_LIMIT(STALL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_sync(field_sync), .mclk_en(mclk_en),
  .bck(bck), .lrck(lrck), .locked(locked)
);

// File: tb/tb_audio_field_clkgen.sv
`timescale 1ns/1ps
module tb_audio_field_clkgen;
  localparam int ACC_W = 16, CNT_W = 18, SDIV_W = 6, LRDIV_W = 8;
  localparam int STALL = 4096, PER = 256, TGT = 100, LOCKN = 4;

  logic clk = 1'b0, rst_n = 1'b0, field_sync = 1'b0;
  logic [CNT_W-1:0]   tgt = CNT_W'(TGT);
  logic [SDIV_W-1:0]  bck_div = 1;
  logic [LRDIV_W-1:0] lr_div = 1;
  logic mclk_en, bck, lrck, locked;

  always #5 clk = ~clk;

  audio_field_clkgen #(.ACC_W(ACC_W), .CNT_W(CNT_W), .SDIV_W(SDIV_W), .LRDIV_W(LRDIV_W),
    .TRIM_SH(8), .ERR_SH(15), .LOCK_N(LOCKN), .STALL_LIMIT(STALL), .INIT_INC(16'd16384)) dut (
    .clk(clk), .rst_n(rst_n), .field_sync(field_sync), .mclk_per_field(tgt),
    .bck_div(bck_div), .lr_div(lr_div), .mclk_en(mclk_en), .bck(bck), .lrck(lrck), .locked(locked));

  int n_cmp = 0, n_bad = 0;
  bit fs_run = 0, primed = 0, exp_lock = 0, seen_lock = 0, prev_bck = 0, prev_lr = 0;
  int phase = 0, fcount = 0, streak = 0, gap = 1, nmeas = 0, npulse = 0;
  int first_meas = 0, second_meas = 0, mc = 0, falls = 0, skip_b = 0, skip_l = 0, win = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit fell, pulse, good;
    int meas;
    @(negedge clk);
    chk(locked === exp_lock, "R5 lock state per field model", int'(locked), int'(exp_lock));
    fell = prev_bck && !bck;
    if (bck !== prev_bck) begin
      if (skip_b > 0) skip_b--;
      else chk(mc == int'(bck_div) + 1, "R8 mclk pulses per bck half", mc, int'(bck_div) + 1);
      mc = 0;
    end
    if (fell) falls++;
    if (lrck !== prev_lr) begin
      chk(fell, "R9 lrck moves only with bck fall", int'(fell), 1);
      if (skip_l > 0) skip_l--;
      else chk(falls == int'(lr_div) + 1, "R9 bck falls per lrck half", falls, int'(lr_div) + 1);
      falls = 0;
    end
    prev_bck = bck;
    prev_lr  = lrck;
    mc += int'(mclk_en);
    win += int'(mclk_en);
    fcount += int'(mclk_en);
    pulse = fs_run && (phase == PER - 1);
    field_sync = pulse;
    if (fs_run) phase = (phase == PER - 1) ? 0 : phase + 1;
    if (pulse) begin
      meas = fcount;
      fcount = 0;
      gap = 0;
      npulse++;
      if (primed) begin
        nmeas++;
        if (nmeas == 1) first_meas = meas;
        if (nmeas == 2) second_meas = meas;
        good = (meas >= TGT - 1) && (meas <= TGT + 1);
        streak = good ? ((streak < LOCKN) ? streak + 1 : LOCKN) : 0;
        exp_lock = good && (streak >= LOCKN);
      end
      primed = 1;
    end else begin
      if (gap == STALL - 1) begin
        streak = 0;
        exp_lock = 0;
        primed = 0;
      end
      if (gap != STALL) gap++;
    end
    if (exp_lock) seen_lock = 1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_500_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sd[6] = '{0, 1, 2, 3, 5, 63};
    int ld[3] = '{0, 1, 3};
    int w1, w2, np0;
    repeat (4) @(negedge clk);
    chk(mclk_en == 0 && bck == 0, "R1 mclk_en/bck low in reset", int'({mclk_en, bck}), 0);
    chk(lrck == 0 && locked == 0, "R1 lrck/locked low in reset", int'({lrck, locked}), 0);
    rst_n = 1'b1;
    // R2: increment 1/4 of the accumulator range -> 256 enables in 1024 cycles
    win = 0;
    run(1024);
    chk(win >= 255 && win <= 257, "R2 mclk_en count over 1024 cycles", win, 256);
    fs_run = 1;
    phase = 0;
    run(62 * PER);
    chk(first_meas == 64, "R3 first measured field at initial increment", first_meas, 64);
    chk(second_meas >= 81 && second_meas <= 83, "R3 field count after one trim", second_meas, 82);
    chk(seen_lock, "R4 lock reached under steady fields", int'(seen_lock), 1);
    chk(locked == 1, "R4 locked after convergence", int'(locked), 1);
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 3; b++) begin
        bck_div = SDIV_W'(sd[a]);
        lr_div  = LRDIV_W'(ld[b]);
        skip_b = 2;
        skip_l = 2;
        run((a == 5) ? 3000 : 1500);
      end
    end
    bck_div = 1;
    lr_div = 1;
    skip_b = 2;
    skip_l = 2;
    run(3 * PER);
    fs_run = 0;
    phase = 0;
    run(100);
    win = 0;
    run(1024);
    w1 = win;
    run(STALL - 1124 - 4);
    chk(locked == exp_lock, "R7 lock held just before stall limit", int'(locked), int'(exp_lock));
    run(400);
    chk(locked == 0, "R7 lock dropped after stall", int'(locked), 0);
    win = 0;
    run(1024);
    w2 = win;
    chk(w2 >= w1 - 1 && w2 <= w1 + 1, "R7 increment held across stall", w2, w1);
    fs_run = 1;
    phase = 0;
    np0 = npulse;
    for (int i = 0; i < 30 * PER && locked !== 1'b1; i++) step();
    chk(npulse - np0 == LOCKN + 1, "R6 pulses needed to relock after stall", npulse - np0, LOCKN + 1);
    run(4 * PER);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule